// File: doc/BRIEF.md
# Threshold Interrupt Comparator with Consecutive-Fault Qualification

This block watches a stream of conversion results and reports when the measured value leaves a programmable band. Each result is sorted into one of three classes: above the upper limit, below the lower limit, or inside the band. A class has to repeat on a programmable number of consecutive results before it is treated as real. That number is 1, 2, 4 or 8. Only a qualified class changes the interrupt line, the upper flag or the lower flag.

A mode input selects one of two reporting styles.

- **Follow mode (mode = 0).** The outputs track the signal with hysteresis. A qualified high excursion raises the interrupt and the upper flag. A qualified low excursion drops the interrupt and raises the lower flag. Results inside the band change nothing, and no clearing action is needed.
- **Hold mode (mode = 1).** Any qualified excursion raises the interrupt and the matching flag. Both stay set until a clear strobe arrives.

Two further outputs support the surrounding logic:

- `alert_ok` tells the bus logic whether it may answer an alert query. This is never allowed in follow mode.
- A polarity input selects whether the interrupt pin is active high or active low.

Results enter on a valid/ready channel:

- A result is taken on a rising clock edge where both `res_valid` and `res_ready` are high.
- `res_ready` is low while reset is applied and on the first clock after reset is released. After that it stays high, so the block never applies back-pressure during operation.
- A source that raises `res_valid` while `res_ready` is low must hold the result until it is accepted.

The limits, mode, fault-count field and polarity are plain control inputs. Changing them never changes the flags by itself.

Top module: `thr_irq_cmp`

## Requirements
- R1: A result is used only on a rising edge where res_valid and res_ready are both 1. res_ready is 0 during reset and on the first edge after reset release, and 1 after that.
- R2: Comparisons are unsigned. A result is ABOVE if res_data > lim_hi, BELOW if res_data < lim_lo, and WITHIN otherwise. If both conditions hold (lim_lo > lim_hi), ABOVE takes priority.
- R3: The 2-bit fault_sel field sets the number of consecutive results needed: values 0, 1, 2 and 3 require 1, 2, 4 and 8 results. A result qualifies when the run of consecutive same-class results, counting itself and saturating at 8, has reached that number. A result of a different class starts a new run at 1. A WITHIN result resets the run to 0.
- R4: In follow mode (latch_mode = 0), a qualified ABOVE result sets the interrupt active, flag_hi to 1 and flag_lo to 0. The change is visible right after the accepting edge.
- R5: In follow mode, a qualified BELOW result sets the interrupt inactive, flag_lo to 1 and flag_hi to 0.
- R6: WITHIN results, and results that are not yet qualified, leave the interrupt and both flags unchanged.
- R7: In follow mode, clr has no effect. Changing the limits, fault_sel or latch_mode without an accepted result changes neither flag nor the interrupt state.
- R8: In hold mode (latch_mode = 1), a qualified ABOVE result sets flag_hi and a qualified BELOW result sets flag_lo. Either one makes the interrupt active. All of them hold until cleared.
- R9: In hold mode, clr drives both flags to 0 and the interrupt to inactive. If a qualified result is accepted on the same edge, the clear is applied first and the result's setting then takes effect.
- R10: irq equals the interrupt state when int_pol = 1 and its inverse when int_pol = 0 (active low). After reset the interrupt is inactive and both flags are 0.
- R11: alert_ok is 1 exactly when latch_mode = 1 and the interrupt is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_valid | input | 1 | Result present |
| res_ready | output | 1 | Block can accept a result |
| res_data | input | DW | Conversion result |
| lim_hi | input | DW | Upper limit |
| lim_lo | input | DW | Lower limit |
| latch_mode | input | 1 | 0 = follow mode, 1 = hold mode |
| fault_sel | input | 2 | Consecutive-result requirement code |
| int_pol | input | 1 | 1 = irq active high, 0 = active low |
| clr | input | 1 | Clear strobe, used only in hold mode |
| irq | output | 1 | Interrupt pin |
| flag_hi | output | 1 | Upper excursion flag |
| flag_lo | output | 1 | Lower excursion flag |
| alert_ok | output | 1 | Alert query may be answered |

## Verification
The two functions that can fall on the same edge are the hold-mode clear and the qualification of a new out-of-band result. The bench raises clr together with res_valid, carrying a value that completes a run. It does this both in directed cases and inside a random stream where clr and valid toggle independently. The check is that the flag matching the new result survives while the opposite flag and any older state are gone, as R9 orders. This is judged every cycle against a behavioural model that applies the clear before the set.

// File: rtl/thr_pkg.sv
package thr_pkg;
  typedef enum logic [1:0] {
    CLS_WITHIN = 2'd0,
    CLS_ABOVE  = 2'd1,
    CLS_BELOW  = 2'd2
  } cls_e;
endpackage

// File: rtl/thr_compare.sv
module thr_compare
  import thr_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  output cls_e          cls_o
);
  logic over_w, under_w;

  assign over_w  = data_i > hi_i;
  assign under_w = data_i < lo_i;

  // upper excursion wins when the band is inverted
  always_comb begin
    if (over_w)       cls_o = CLS_ABOVE;
    else if (under_w) cls_o = CLS_BELOW;
    else              cls_o = CLS_WITHIN;
  end
endmodule

// File: rtl/thr_fault_qual.sv
module thr_fault_qual
  import thr_pkg::*;
#(
  parameter int FCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_i,
  input  cls_e           cls_i,
  input  logic [FCW-1:0] fsel_i,
  output logic           qual_o,
  output cls_e           qual_cls_o
);
  localparam int MAXN = 1 << ((1 << FCW) - 1);
  localparam int CNTW = $clog2(MAXN + 1);

  logic [CNTW-1:0] cnt_q, cnt_nxt, need_w;
  cls_e            last_q, last_nxt;

  assign need_w = CNTW'(1) << fsel_i;

  always_comb begin
    cnt_nxt  = cnt_q;
    last_nxt = last_q;
    if (acc_i) begin
      if (cls_i == CLS_WITHIN) begin
        cnt_nxt  = '0;
        last_nxt = CLS_WITHIN;
      end else if (cls_i == last_q) begin
        cnt_nxt = (cnt_q == CNTW'(MAXN)) ? cnt_q : cnt_q + CNTW'(1);
      end else begin
        cnt_nxt  = CNTW'(1);
        last_nxt = cls_i;
      end
    end
  end

  assign qual_o     = acc_i && (cls_i != CLS_WITHIN) && (cnt_nxt >= need_w);
  assign qual_cls_o = cls_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= CLS_WITHIN;
    end else begin
      cnt_q  <= cnt_nxt;
      last_q <= last_nxt;
    end
  end

  AST_WITHIN_RESETS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_i && cls_i == CLS_WITHIN) |=> (cnt_q == '0)); // R3

  AST_QUAL_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_o && need_w != CNTW'(1)) |-> (last_q == cls_i)); // R3
endmodule

// File: rtl/thr_report.sv
module thr_report
  import thr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc_i,
  input  logic qual_i,
  input  cls_e qual_cls_i,
  input  logic latch_i,
  input  logic clr_i,
  output logic fh_o,
  output logic fl_o,
  output logic act_o
);
  logic fh_n, fl_n, act_n;

  always_comb begin
    fh_n  = fh_o;
    fl_n  = fl_o;
    act_n = act_o;
    if (latch_i) begin
      if (clr_i) begin
        fh_n  = 1'b0;
        fl_n  = 1'b0;
        act_n = 1'b0;
      end
      if (qual_i) begin
        act_n = 1'b1;
        if (qual_cls_i == CLS_ABOVE) fh_n = 1'b1;
        else                         fl_n = 1'b1;
      end
    end else if (qual_i) begin
      if (qual_cls_i == CLS_ABOVE) begin
        fh_n  = 1'b1;
        fl_n  = 1'b0;
        act_n = 1'b1;
      end else begin
        fh_n  = 1'b0;
        fl_n  = 1'b1;
        act_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fh_o  <= 1'b0;
      fl_o  <= 1'b0;
      act_o <= 1'b0;
    end else begin
      fh_o  <= fh_n;
      fl_o  <= fl_n;
      act_o <= act_n;
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!acc_i && !(latch_i && clr_i)) |=> $stable({fh_o, fl_o, act_o})); // R7

  AST_FOLLOW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (qual_i && !latch_i) |=> ($countones({fh_o, fl_o}) == 1)); // R4

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_i && !clr_i && fh_o) |=> fh_o); // R8

  AST_CLEAR_WINS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_i && clr_i && !qual_i) |=> (!fh_o && !fl_o && !act_o)); // R9
endmodule

// File: rtl/thr_irq_cmp.sv
module thr_irq_cmp
  import thr_pkg::*;
#(
  parameter int DW  = 16,
  parameter int FCW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           res_valid,
  output logic           res_ready,
  input  logic [DW-1:0]  res_data,
  input  logic [DW-1:0]  lim_hi,
  input  logic [DW-1:0]  lim_lo,
  input  logic           latch_mode,
  input  logic [FCW-1:0] fault_sel,
  input  logic           int_pol,
  input  logic           clr,
  output logic           irq,
  output logic           flag_hi,
  output logic           flag_lo,
  output logic           alert_ok
);
  logic rdy_q, acc_w, qual_w, act_w;
  cls_e cls_w, qcls_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= 1'b0;
    else        rdy_q <= 1'b1;
  end

  assign res_ready = rdy_q;
  assign acc_w     = res_valid && rdy_q;

  thr_compare #(.DW(DW)) u_cmp (
    .data_i (res_data),
    .hi_i   (lim_hi),
    .lo_i   (lim_lo),
    .cls_o  (cls_w)
  );

  thr_fault_qual #(.FCW(FCW)) u_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_i      (acc_w),
    .cls_i      (cls_w),
    .fsel_i     (fault_sel),
    .qual_o     (qual_w),
    .qual_cls_o (qcls_w)
  );

  thr_report u_rep (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_i      (acc_w),
    .qual_i     (qual_w),
    .qual_cls_i (qcls_w),
    .latch_i    (latch_mode),
    .clr_i      (clr),
    .fh_o       (flag_hi),
    .fl_o       (flag_lo),
    .act_o      (act_w)
  );

  assign irq      = int_pol ? act_w : ~act_w;
  assign alert_ok = latch_mode && act_w;

  AST_NOT_READY_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (!res_ready && !(latch_mode && clr)) |=> $stable({flag_hi, flag_lo})); // R1
endmodule

// File: tb/test_thr_irq_cmp.sv
module test_thr_irq_cmp;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic res_valid = 1'b0;
  logic res_ready;
  logic [15:0] res_data = '0, lim_hi = 16'd3000, lim_lo = 16'd1000;
  logic latch_mode = 1'b0;
  logic [1:0] fault_sel = 2'd0;
  logic int_pol = 1'b0;
  logic clr = 1'b0;
  logic irq, flag_hi, flag_lo, alert_ok;

  int total = 0;
  int bad = 0;

  // behavioural reference state
  int m_rdy = 0, m_fh = 0, m_fl = 0, m_act = 0, m_cnt = 0, m_cls = 0;

  always #2 clk = ~clk;

  thr_irq_cmp i_thr_irq_cmp (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .lim_hi(lim_hi), .lim_lo(lim_lo),
    .latch_mode(latch_mode), .fault_sel(fault_sel), .int_pol(int_pol),
    .clr(clr), .irq(irq), .flag_hi(flag_hi), .flag_lo(flag_lo),
    .alert_ok(alert_ok)
  );

  // class codes: 0 within, 1 above, 2 below (R2)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy = 0; m_fh = 0; m_fl = 0; m_act = 0; m_cnt = 0; m_cls = 0;
    end else begin
      int c, need;
      bit q;
      bit acc;
      acc = res_valid && (m_rdy == 1);
      c = (res_data > lim_hi) ? 1 : (res_data < lim_lo) ? 2 : 0;
      need = 1 << fault_sel;
      q = 0;
      if (acc) begin
        if (c == 0) begin m_cnt = 0; m_cls = 0; end
        else if (c == m_cls) begin if (m_cnt < 8) m_cnt++; end
        else begin m_cnt = 1; m_cls = c; end
        q = (c != 0) && (m_cnt >= need);
      end
      if (latch_mode) begin
        if (clr) begin m_fh = 0; m_fl = 0; m_act = 0; end
        if (q) begin m_act = 1; if (c == 1) m_fh = 1; else m_fl = 1; end
      end else if (q) begin
        if (c == 1) begin m_fh = 1; m_fl = 0; m_act = 1; end
        else        begin m_fh = 0; m_fl = 1; m_act = 0; end
      end
      m_rdy = 1;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    int eirq;
    eirq = int_pol ? m_act : (m_act == 0);
    chk(res_ready == m_rdy, "R1 res_ready", res_ready, m_rdy);
    chk(flag_hi == m_fh, "R4/R8 flag_hi", flag_hi, m_fh);
    chk(flag_lo == m_fl, "R5/R8 flag_lo", flag_lo, m_fl);
    chk(irq == eirq, "R10 irq", irq, eirq);
    chk(alert_ok == (latch_mode && m_act), "R11 alert_ok", alert_ok, latch_mode && m_act);
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic send(input int d);
    res_valid = 1'b1; res_data = 16'(d);
    step();
    res_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    #1;
    chk(irq == 1'b1, "R10 reset irq active-low idle", irq, 1);
    chk(res_ready == 1'b0, "R1 ready low in reset", res_ready, 0);
    repeat (3) step();
    rst_n = 1'b1;
    // value offered before ready must not count (R1)
    res_valid = 1'b1; res_data = 16'd5000;
    #1 chk(res_ready == 1'b0, "R1 ready low first cycle", res_ready, 0);
    step();
    chk(flag_hi == 1'b0, "R1 not taken while not ready", flag_hi, 0);
    res_valid = 1'b0;
    step();

    // R4 follow, single result
    send(4000);
    chk(flag_hi == 1 && flag_lo == 0, "R4 above sets flag_hi", flag_hi, 1);
    chk(irq == 1'b0, "R4/R10 irq active low", irq, 0);
    // R6 within leaves state
    send(2000);
    chk(flag_hi == 1, "R6 within keeps flag_hi", flag_hi, 1);
    // R7 clr ignored, limit change ignored
    clr = 1'b1; lim_hi = 16'd10; step(); clr = 1'b0; lim_hi = 16'd3000; step();
    chk(flag_hi == 1, "R7 clr ignored in follow mode", flag_hi, 1);
    // R5 below
    send(500);
    chk(flag_lo == 1 && flag_hi == 0, "R5 below sets flag_lo", flag_lo, 1);
    chk(irq == 1'b1, "R5 irq inactive", irq, 1);

    // R3 need 8, broken run
    fault_sel = 2'd3;
    repeat (7) send(3500);
    chk(flag_hi == 0, "R3 seven not enough", flag_hi, 0);
    send(2000);
    repeat (7) send(3500);
    chk(flag_hi == 0, "R3 run restarted by within", flag_hi, 0);
    send(3500);
    chk(flag_hi == 1, "R3 eighth qualifies", flag_hi, 1);
    fault_sel = 2'd1;
    send(100);
    chk(flag_hi == 1, "R3 one below not enough at 2", flag_hi, 1);
    send(100);
    chk(flag_lo == 1, "R3 two below qualify", flag_lo, 1);

    // R2 inverted band: above wins
    fault_sel = 2'd0; lim_hi = 16'd100; lim_lo = 16'd200;
    send(150);
    chk(flag_hi == 1, "R2 above priority", flag_hi, 1);
    lim_hi = 16'd3000; lim_lo = 16'd1000;

    // R8 hold mode
    latch_mode = 1'b1; int_pol = 1'b1;
    send(500);
    chk(flag_lo == 1 && flag_hi == 1, "R8 both flags latched", flag_lo, 1);
    chk(alert_ok == 1, "R11 alert in hold mode", alert_ok, 1);
    send(2000);
    chk(irq == 1, "R8 hold through within", irq, 1);
    clr = 1'b1; step(); clr = 1'b0;
    chk(flag_hi == 0 && flag_lo == 0 && irq == 0, "R9 clear", flag_hi, 0);
    send(4000);
    // R9 clear and qualified below on one edge
    clr = 1'b1; send(300); clr = 1'b0;
    chk(flag_lo == 1 && flag_hi == 0, "R9 set after clear", flag_hi, 0);
    chk(irq == 1, "R9 irq after same-cycle set", irq, 1);

    // random streams, both modes, model compared every cycle
    for (int ph = 0; ph < 4; ph++) begin
      latch_mode = ph[0];
      int_pol = ph[1];
      for (int i = 0; i < 3000; i++) begin
        res_valid = ($urandom_range(0, 3) != 0);
        res_data  = 16'($urandom_range(0, 4000));
        clr       = ($urandom_range(0, 15) == 0);
        if ($urandom_range(0, 63) == 0) fault_sel = 2'($urandom_range(0, 3));
        step();
      end
      res_valid = 1'b0; clr = 1'b0;
      step();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule